// File: doc/BRIEF.md
# Thermal Threshold Throttle Controller

This block watches a stream of die temperature samples, given in whole degrees Celsius, and decides how hard the rest of the chip must be throttled. Two configurable throttle thresholds and one trip threshold are compared against each accepted sample. The lower throttle threshold requests either 90% or 50% throttling, chosen by a policy bit. The upper one forces 100% throttling. Reaching the trip level raises a shutdown request for an external management controller. This request stays latched until reset.

A small bank of 64-bit registers is reached over a plain address/data port. One register holds the threshold values, their enables, the policy bit, and two live status bits. Another reads back the last accepted temperature, and a third reports whether automatic throttling is built in. The capability is a build parameter. When throttling is not built in, the throttle output stays at "none", while status and shutdown behave as usual. The block does not sense temperature and does not gate clocks; it only emits the throttle code and the shutdown request.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: After reset the throttle code is 00, the shutdown request is low, and the temperature register reads 0. The threshold register (byte offset 0x08) reads 0x6E00E4DA: lower threshold 90 in bits 6:0 with its enable in bit 7 set, upper threshold 100 in bits 14:8 with its enable in bit 15 set, trip 110 in bits 30:24, and policy bit 44 clear.
- R2: A sample presented with `temp_valid` high is stored, and it reads back from bits 6:0 at offset 0x10 from the next cycle on. A sample presented with `temp_valid` low is not stored.
- R3: Bit 32 of the threshold register reads 1 exactly when the stored temperature is at or above the lower threshold. Bit 33 does the same for the upper threshold. Both bits follow the comparison whether or not the enables are set.
- R4: When the upper level does not apply, a sample at or above an enabled lower threshold gives code 10 (90%) if policy bit 44 is 0, and code 01 (50%) if it is 1.
- R5: A sample at or above an enabled upper threshold gives code 11 (100%). This overrides the lower-threshold level.
- R6: A threshold whose enable bit is clear produces no throttling. A sample below every enabled threshold gives code 00.
- R7: The throttle code is registered. It takes its new value in the cycle after a valid sample and holds while `temp_valid` is low.
- R8: A valid sample at or above the trip threshold raises `shutdown_req` in the next cycle. The request then stays high until reset, whatever the later samples are.
- R9: The capability register at offset 0x20 reads 1 in bit 0 when throttling is not built in (parameter `NO_THROTTLE`=1) and 0 otherwise. When it is not built in, the throttle code is always 00, and status and shutdown still work.
- R10: A write to offset 0x08 updates only the threshold, enable, trip and policy fields; the other bits, including status, ignore it. Writes to any other offset have no effect. Reads of offsets other than 0x08, 0x10 and 0x20 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| temp_valid | input | 1 | Qualifies `temp_sample` for this cycle |
| temp_sample | input | 7 | Die temperature, whole degrees Celsius |
| reg_addr | input | ADDR_W | Register byte offset for reads and writes |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational |
| throttle_code | output | 2 | 00 none, 01 50%, 10 90%, 11 100% |
| shutdown_req | output | 1 | Sticky fatal shutdown request |

## Verification
The throttle code, the shutdown request and the stored temperature each change one clock after the edge that accepts a valid sample. The status bits follow the stored temperature with no further delay. Register reads are combinational, and a write takes effect from the next cycle. The bench drives each sample on a falling edge and drops `temp_valid` on the next falling edge, so exactly one rising edge separates stimulus from check, and it samples outputs and read data at that second falling edge. Hold behaviour is checked after several idle cycles in which a different sample value is driven with `temp_valid` low.

// File: rtl/thermal_pkg.sv
// Package: shared types, register offsets and field positions for the
// thermal throttle controller. Field positions are fixed because software
// decodes them; the struct keeps the configuration together inside the RTL.
package thermal_pkg;

    localparam int TEMP_W = 7;
    localparam int WORD_W = 64;

    // Byte offsets of the mapped registers
    localparam logic [7:0] OFF_THRESH = 8'h08;
    localparam logic [7:0] OFF_TEMP   = 8'h10;
    localparam logic [7:0] OFF_CAP    = 8'h20;

    // Bit positions inside the threshold register
    localparam int POS_LO      = 0;
    localparam int POS_LO_EN   = 7;
    localparam int POS_HI      = 8;
    localparam int POS_HI_EN   = 15;
    localparam int POS_TRIP    = 24;
    localparam int POS_ST_LO   = 32;
    localparam int POS_ST_HI   = 33;
    localparam int POS_POLICY  = 44;

    typedef enum logic [1:0] {
        THR_NONE   = 2'b00,
        THR_HALF   = 2'b01,
        THR_NINETY = 2'b10,
        THR_FULL   = 2'b11
    } thr_code_e;

    typedef struct packed {
        logic              policy_half;
        logic [TEMP_W-1:0] trip;
        logic              hi_en;
        logic [TEMP_W-1:0] hi;
        logic              lo_en;
        logic [TEMP_W-1:0] lo;
    } thr_cfg_t;

    // Assemble the threshold register word from configuration and live status
    function automatic logic [WORD_W-1:0] pack_thresh(thr_cfg_t c, logic st_lo, logic st_hi);
        logic [WORD_W-1:0] w;
        w = '0;
        w[POS_LO +: TEMP_W]   = c.lo;
        w[POS_LO_EN]          = c.lo_en;
        w[POS_HI +: TEMP_W]   = c.hi;
        w[POS_HI_EN]          = c.hi_en;
        w[POS_TRIP +: TEMP_W] = c.trip;
        w[POS_ST_LO]          = st_lo;
        w[POS_ST_HI]          = st_hi;
        w[POS_POLICY]         = c.policy_half;
        return w;
    endfunction

endpackage

// File: rtl/thermal_cfg_regs.sv
// Module: thermal_cfg_regs
// Holds the writable threshold configuration. Assumes the write strobe is
// already decoded to the threshold offset; status bits are never stored here.
module thermal_cfg_regs
    import thermal_pkg::*;
#(
    parameter int LO_RST   = 90,
    parameter int HI_RST   = 100,
    parameter int TRIP_RST = 110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output thr_cfg_t          cfg
);

    localparam logic [TEMP_W-1:0] LO_INIT   = TEMP_W'(LO_RST);
    localparam logic [TEMP_W-1:0] HI_INIT   = TEMP_W'(HI_RST);
    localparam logic [TEMP_W-1:0] TRIP_INIT = TEMP_W'(TRIP_RST);

    // Load safe defaults on reset, otherwise capture the writable fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.lo          <= LO_INIT;
            cfg.lo_en       <= 1'b1;
            cfg.hi          <= HI_INIT;
            cfg.hi_en       <= 1'b1;
            cfg.trip        <= TRIP_INIT;
            cfg.policy_half <= 1'b0;
        end else if (wr_en) begin
            cfg.lo          <= wdata[POS_LO +: TEMP_W];
            cfg.lo_en       <= wdata[POS_LO_EN];
            cfg.hi          <= wdata[POS_HI +: TEMP_W];
            cfg.hi_en       <= wdata[POS_HI_EN];
            cfg.trip        <= wdata[POS_TRIP +: TEMP_W];
            cfg.policy_half <= wdata[POS_POLICY];
        end
    end

endmodule

// File: rtl/thermal_level_eval.sv
// Module: thermal_level_eval
// Purely combinational: compares one temperature against the configured
// thresholds and picks the most severe throttle level. All comparisons are
// inclusive. NO_THROTTLE selects a variant whose level is always "none".
module thermal_level_eval
    import thermal_pkg::*;
#(
    parameter bit NO_THROTTLE = 1'b0
) (
    input  logic [TEMP_W-1:0] temp,
    input  thr_cfg_t          cfg,
    output logic              reach_lo,
    output logic              reach_hi,
    output logic              reach_trip,
    output thr_code_e         level
);

    // Inclusive threshold comparisons, independent of the enables
    always_comb begin
        reach_lo   = (temp >= cfg.lo);
        reach_hi   = (temp >= cfg.hi);
        reach_trip = (temp >= cfg.trip);
    end

    generate
        if (NO_THROTTLE) begin : g_no_thr
            // Throttling not built in: level is fixed at none
            always_comb level = THR_NONE;
        end else begin : g_thr
            // Priority pick: full, then the policy level, then none
            always_comb begin
                if (cfg.hi_en && reach_hi)
                    level = THR_FULL;
                else if (cfg.lo_en && reach_lo)
                    level = cfg.policy_half ? THR_HALF : THR_NINETY;
                else
                    level = THR_NONE;
            end
        end
    endgenerate

endmodule

// File: rtl/thermal_readback.sv
// Module: thermal_readback
// Combinational read multiplexer over the three mapped registers. Assumes
// byte offsets; every unmapped offset returns zero.
module thermal_readback
    import thermal_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter bit NO_THROTTLE = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  thr_cfg_t          cfg,
    input  logic [TEMP_W-1:0] temp,
    input  logic              st_lo,
    input  logic              st_hi,
    output logic [WORD_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_THRESH = ADDR_W'(OFF_THRESH);
    localparam logic [ADDR_W-1:0] A_TEMP   = ADDR_W'(OFF_TEMP);
    localparam logic [ADDR_W-1:0] A_CAP    = ADDR_W'(OFF_CAP);

    // Select the addressed register word
    always_comb begin
        rdata = '0;
        if (addr == A_THRESH)
            rdata = pack_thresh(cfg, st_lo, st_hi);
        else if (addr == A_TEMP)
            rdata[TEMP_W-1:0] = temp;
        else if (addr == A_CAP)
            rdata[0] = NO_THROTTLE;
    end

endmodule

// File: rtl/thermal_throttle_ctrl.sv
// Module: thermal_throttle_ctrl (top)
// Accepts qualified temperature samples, registers the throttle code and a
// sticky shutdown request one cycle after each valid sample, and exposes the
// configuration, temperature and capability registers on a simple bus.
// Assumes the sample is already in whole degrees Celsius.
module thermal_throttle_ctrl
    import thermal_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter bit NO_THROTTLE = 1'b0,
    parameter int LO_RST      = 90,
    parameter int HI_RST      = 100,
    parameter int TRIP_RST    = 110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_valid,
    input  logic [6:0]        temp_sample,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic [1:0]        throttle_code,
    output logic              shutdown_req
);

    localparam logic [ADDR_W-1:0] A_THRESH = ADDR_W'(OFF_THRESH);

    thr_cfg_t          cfg_q;
    logic [TEMP_W-1:0] temp_q;
    logic              cfg_wr;
    logic              smp_lo, smp_hi, smp_trip;
    thr_code_e         smp_level;
    logic              st_lo, st_hi, st_trip;
    thr_code_e         st_level;
    thr_code_e         code_q;

    // Decode a write to the threshold register
    always_comb cfg_wr = reg_wen && (reg_addr == A_THRESH);

    thermal_cfg_regs #(
        .LO_RST   (LO_RST),
        .HI_RST   (HI_RST),
        .TRIP_RST (TRIP_RST)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .wdata (reg_wdata),
        .cfg   (cfg_q)
    );

    // Evaluator on the incoming sample: drives the registered outputs
    thermal_level_eval #(.NO_THROTTLE(NO_THROTTLE)) u_eval_smp (
        .temp       (temp_sample),
        .cfg        (cfg_q),
        .reach_lo   (smp_lo),
        .reach_hi   (smp_hi),
        .reach_trip (smp_trip),
        .level      (smp_level)
    );

    // Evaluator on the stored temperature: drives the live status bits
    thermal_level_eval #(.NO_THROTTLE(NO_THROTTLE)) u_eval_st (
        .temp       (temp_q),
        .cfg        (cfg_q),
        .reach_lo   (st_lo),
        .reach_hi   (st_hi),
        .reach_trip (st_trip),
        .level      (st_level)
    );

    // Capture the temperature and throttle level on each valid sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_q <= '0;
            code_q <= THR_NONE;
        end else if (temp_valid) begin
            temp_q <= temp_sample;
            code_q <= smp_level;
        end
    end

    // Latch the shutdown request until reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            shutdown_req <= 1'b0;
        else if (temp_valid && smp_trip)
            shutdown_req <= 1'b1;
    end

    thermal_readback #(
        .ADDR_W      (ADDR_W),
        .NO_THROTTLE (NO_THROTTLE)
    ) u_rb (
        .addr  (reg_addr),
        .cfg   (cfg_q),
        .temp  (temp_q),
        .st_lo (st_lo),
        .st_hi (st_hi),
        .rdata (reg_rdata)
    );

    // Drive the throttle code port from its register
    always_comb throttle_code = code_q;

    // The stored-temperature evaluator's level and trip flag feed nothing
    logic unused_st;
    always_comb unused_st = st_trip ^ (^st_level) ^ smp_lo ^ smp_hi;

endmodule

// File: rtl/thermal_throttle_chk.sv
// Module: thermal_throttle_chk
// Checker bound to the top. Relates the accepted sample and configuration
// to the registered outputs one cycle later. A flag marks cycles whose
// previous cycle was already out of reset, so no $past looks before reset.
module thermal_throttle_chk
    import thermal_pkg::*;
#(
    parameter bit NO_THROTTLE = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              temp_valid,
    input logic [TEMP_W-1:0] temp_sample,
    input thr_cfg_t          cfg_q,
    input logic [1:0]        throttle_code,
    input logic              shutdown_req
);

    logic run_q;

    // Mark that the previous cycle was out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    // R7: code holds when no valid sample was accepted
    p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !$past(temp_valid)) |-> $stable(throttle_code));

    // R8: shutdown request is sticky
    p_shutdown_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(shutdown_req)) |-> shutdown_req);

    // R8: sample at or above trip raises shutdown next cycle
    p_trip_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(temp_valid) && ($past(temp_sample) >= $past(cfg_q.trip)))
        |-> shutdown_req);

    // R5: enabled upper threshold reached gives full throttle
    p_full_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!NO_THROTTLE && run_q && $past(temp_valid) && $past(cfg_q.hi_en)
         && ($past(temp_sample) >= $past(cfg_q.hi))) |-> (throttle_code == 2'b11));

    // R6: below every enabled threshold gives no throttle
    p_below_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(temp_valid)
         && !($past(cfg_q.hi_en) && ($past(temp_sample) >= $past(cfg_q.hi)))
         && !($past(cfg_q.lo_en) && ($past(temp_sample) >= $past(cfg_q.lo))))
        |-> (throttle_code == 2'b00));

    // R9: without built-in throttling the code stays at none
    p_no_throttle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        NO_THROTTLE |-> (throttle_code == 2'b00));

endmodule

bind thermal_throttle_ctrl thermal_throttle_chk #(.NO_THROTTLE(NO_THROTTLE)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .temp_valid    (temp_valid),
    .temp_sample   (temp_sample),
    .cfg_q         (cfg_q),
    .throttle_code (throttle_code),
    .shutdown_req  (shutdown_req)
);

// File: tb/tb_thermal_throttle_ctrl.sv
// Directed bench: one task per scenario. A second instance built without
// throttling shares all stimulus and is checked alongside.
module tb_thermal_throttle_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        temp_valid = 1'b0;
    logic [6:0]  temp_sample = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] rdata, rdata_nt;
    logic [1:0]  code, code_nt;
    logic        sdn, sdn_nt;

    int checks = 0;
    int fails  = 0;

    localparam logic [63:0] DEF_THR = 64'h0000_0000_6E00_E4DA;

    always #5 clk = ~clk;

    thermal_throttle_ctrl dut (
        .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_sample(temp_sample),
        .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
        .reg_rdata(rdata), .throttle_code(code), .shutdown_req(sdn)
    );

    thermal_throttle_ctrl #(.NO_THROTTLE(1'b1)) dut_nt (
        .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_sample(temp_sample),
        .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_nt), .throttle_code(code_nt), .shutdown_req(sdn_nt)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One rising edge between drive and the returning negedge
    task automatic send(logic [6:0] t);
        @(negedge clk); temp_valid = 1'b1; temp_sample = t;
        @(negedge clk); temp_valid = 1'b0;
        check("R9 no-throttle code", {62'd0, code_nt}, 64'd0);
    endtask

    task automatic wr(logic [7:0] a, logic [63:0] d);
        @(negedge clk); reg_addr = a; reg_wen = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wen = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [63:0] v, output logic [63:0] vnt);
        reg_addr = a; #1; v = rdata; vnt = rdata_nt;
    endtask

    task automatic t_reset();
        logic [63:0] v, vn;
        check("R1 code", {62'd0, code}, 64'd0);
        check("R1 shutdown", {63'd0, sdn}, 64'd0);
        rd(8'h08, v, vn); check("R1 thresh reg", v, DEF_THR);
        rd(8'h10, v, vn); check("R1 temp reg", v, 64'd0);
        rd(8'h20, v, vn); check("R9 cap reg", v, 64'd0);
        check("R9 cap reg no-throttle", vn, 64'd1);
    endtask

    task automatic t_readback();
        logic [63:0] v, vn;
        send(7'd45);
        rd(8'h10, v, vn); check("R2 temp stored", v, 64'd45);
        @(negedge clk); temp_sample = 7'd77;
        repeat (2) @(negedge clk);
        rd(8'h10, v, vn); check("R2 invalid sample ignored", v, 64'd45);
    endtask

    task automatic t_levels();
        logic [63:0] v, vn;
        send(7'd89);
        check("R6 below lower", {62'd0, code}, 64'd0);
        rd(8'h08, v, vn); check("R3 status below", v[33:32], 64'd0);
        send(7'd90);
        check("R4 at lower policy0", {62'd0, code}, 64'd2);
        rd(8'h08, v, vn); check("R3 status at lower", v[33:32], 64'd1);
        send(7'd99);
        check("R4 just under upper", {62'd0, code}, 64'd2);
        send(7'd100);
        check("R5 at upper", {62'd0, code}, 64'd3);
        rd(8'h08, v, vn); check("R3 status at upper", v[33:32], 64'd3);
    endtask

    task automatic t_hold();
        @(negedge clk); temp_sample = 7'd10;
        repeat (4) @(negedge clk);
        check("R7 code holds", {62'd0, code}, 64'd3);
        send(7'd95);
        check("R7 code updates", {62'd0, code}, 64'd2);
    endtask

    task automatic t_policy();
        logic [63:0] v, vn;
        wr(8'h08, DEF_THR | (64'd1 << 44));
        rd(8'h08, v, vn); check("R10 policy written", v, DEF_THR | (64'd1 << 44) | (64'd1 << 32));
        send(7'd95);
        check("R4 policy1 half", {62'd0, code}, 64'd1);
        send(7'd101);
        check("R5 full over policy", {62'd0, code}, 64'd3);
    endtask

    task automatic t_enables();
        logic [63:0] v, vn;
        wr(8'h08, 64'h0000_0000_6E00_64DA);
        send(7'd105);
        check("R6 upper disabled", {62'd0, code}, 64'd2);
        rd(8'h08, v, vn); check("R3 status with enable clear", v[33:32], 64'd3);
        wr(8'h08, 64'h0000_0000_6E00_645A);
        send(7'd105);
        check("R6 both disabled", {62'd0, code}, 64'd0);
    endtask

    task automatic t_write_mask();
        logic [63:0] v, vn;
        wr(8'h08, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(8'h08, v, vn); check("R10 write mask", v, 64'h0000_1000_7F00_FFFF);
        wr(8'h10, 64'h33);
        rd(8'h10, v, vn); check("R10 temp not writable", v, 64'd105);
        rd(8'h18, v, vn); check("R10 unmapped 0x18", v, 64'd0);
        rd(8'h00, v, vn); check("R10 unmapped 0x00", v, 64'd0);
        wr(8'h08, DEF_THR);
    endtask

    task automatic t_trip();
        send(7'd109);
        check("R8 below trip", {63'd0, sdn}, 64'd0);
        send(7'd110);
        check("R8 at trip", {63'd0, sdn}, 64'd1);
        check("R8 no-throttle shutdown", {63'd0, sdn_nt}, 64'd1);
        send(7'd20);
        check("R8 sticky", {63'd0, sdn}, 64'd1);
        check("R6 cool after trip", {62'd0, code}, 64'd0);
        do_reset();
        check("R8 cleared by reset", {63'd0, sdn}, 64'd0);
    endtask

    task automatic t_no_throttle();
        logic [63:0] v, vn;
        send(7'd120);
        check("R5 hot sample", {62'd0, code}, 64'd3);
        check("R9 shutdown works", {63'd0, sdn_nt}, 64'd1);
        rd(8'h08, v, vn); check("R9 status works", vn, DEF_THR | (64'd3 << 32));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        t_reset();
        t_readback();
        t_levels();
        t_hold();
        t_policy();
        t_enables();
        t_write_mask();
        t_trip();
        t_no_throttle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule